// File: doc/BRIEF.md
# Gated Event Counter with Priming Pulse

This block counts detector pulses during a time window that software opens and closes. Software preloads a 16-bit down-counter, usually with all ones, and opens the gate. Each conditioned event then takes one off the count. After the gate is closed, software reads the count back. The bitwise complement of the value read is the number of events seen in the window.

The counting stage has a quirk: it ignores the first edge after the gate opens. To make up for it, the block injects one synthetic event a fixed delay after the gate opens, so that edge is used up. Zero real events and one real event therefore give different readings.

The event input is asynchronous and may be noisy. It passes through a two-flop synchroniser and then a pulse shaper. The shaper turns each leading edge into a pulse of fixed width and ignores further edges while that pulse is active. A read captures the live count into a holding register, so software never sees a value that is partway through a change. A sticky flag records any wrap of the count past zero.

Top module: `gated_event_counter`

## Requirements
- R1: After reset, the count is 0, the gate is closed, the wrap flag `wrapped` is 0, and a read returns 0.
- R2: A write with `wr_addr`=0 loads `wr_data` into the count and clears `wrapped`. A write with `wr_addr`=1 sets the gate to `wr_data[0]` (1 = open).
- R3: While the gate is open, each conditioned event lowers the count by exactly one. After a preload of FFFFh, the complement of the value read equals the number of real events.
- R4: The synthetic priming event, issued `PRIME_CYC` cycles after the gate opens, is absorbed by the non-decrementing first edge. A window with no real events reads FFFFh, and a window with one real event reads FFFEh.
- R5: Events that arrive while the gate is closed do not change the count.
- R6: A rising edge of the synchronised input starts a shaped pulse `PULSE_W` cycles wide. Rising edges that arrive while that pulse is active are ignored, and only the end of the pulse counts as an event.
- R7: A real event whose counted edge falls in the same cycle as the priming event, or just before or after it, is still counted exactly once.
- R8: A decrement from 0 wraps the count to FFFFh and sets `wrapped`. The flag stays set until the next load.
- R9: A read pulse on `rd_strobe` copies the count into `rd_data` at the next clock edge and raises `rd_valid` for one cycle. `rd_data` holds that copy until the next read pulse, even while the count keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0: load the count, 1: gate control |
| wr_data | input | 16 | Write data |
| rd_strobe | input | 1 | Read request; copies the count into `rd_data` |
| rd_data | output | 16 | Count copy taken at the last read |
| rd_valid | output | 1 | High for one cycle after a read |
| evt_in | input | 1 | Asynchronous detector pulse input |
| wrapped | output | 1 | Sticky flag: the count wrapped past zero |

## Verification
Two edges can reach the counter in the same clock cycle: the falling edge of a shaped real event and the priming event. When the first-edge skip is still pending, exactly one of the two must be dropped. The bench provokes this by opening the gate and then placing a single real pulse at offsets that sweep about ten cycles across the priming instant. Every offset must read back FFFEh: an edge counted twice, or an edge lost, shows up as a different value.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic {
    SEL_LOAD = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/gec_sync_edge.sv
module gec_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/gec_shaper.sv
module gec_shaper #(
  parameter int PULSE_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse,
  output logic fall_stb
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] WIDTH = CW'(PULSE_W);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left     <= '0;
      fall_stb <= 1'b0;
    end else begin
      if (trig && left == '0) left <= WIDTH;
      else if (left != '0)    left <= left - 1'b1;
      fall_stb <= (left == CW'(1));
    end
  end

  assign pulse = (left != '0);

  // R6: an edge during an active pulse does not restart it
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (trig && left > CW'(1)) |=> (left == $past(left) - 1'b1));
  // R6: the end-of-pulse strobe lasts exactly one cycle
  assert_single_fall_R6: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !fall_stb);
endmodule

// File: rtl/gec_prime.sv
module gec_prime #(
  parameter int PRIME_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic prime_stb
);
  localparam int CW = $clog2(PRIME_CYC + 1);
  localparam logic [CW-1:0] DLY = CW'(PRIME_CYC);

  logic          gate_d;
  logic [CW-1:0] wait_cnt;
  logic          opened;

  assign opened = gate & ~gate_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d    <= 1'b0;
      wait_cnt  <= '0;
      prime_stb <= 1'b0;
    end else begin
      gate_d <= gate;
      if (!gate)                 wait_cnt <= '0;
      else if (opened)           wait_cnt <= DLY;
      else if (wait_cnt != '0)   wait_cnt <= wait_cnt - 1'b1;
      prime_stb <= gate && !opened && (wait_cnt == CW'(1));
    end
  end

  // R4: the priming event is a single-cycle strobe
  assert_prime_single_R4: assert property (@(posedge clk) disable iff (rst)
    prime_stb |=> !prime_stb);
  // R4: the priming event is only issued while the gate was open
  assert_prime_gated_R4: assert property (@(posedge clk) disable iff (rst)
    prime_stb |-> $past(gate));
endmodule

// File: rtl/gec_core.sv
module gec_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ev_stb,
  input  logic             prime_stb,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic       gate_d;
  logic       skip_pend;
  logic       opened;
  logic [1:0] n_edges;
  logic       take;
  logic       skip_now;
  logic [1:0] dec;

  assign opened   = gate & ~gate_d;
  assign n_edges  = {1'b0, ev_stb} + {1'b0, prime_stb};
  assign take     = gate && (n_edges != 2'd0);
  assign skip_now = skip_pend | opened;

  always_comb begin
    dec = 2'd0;
    if (take) dec = skip_now ? n_edges - 2'd1 : n_edges;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d    <= 1'b0;
      skip_pend <= 1'b0;
      cnt       <= '0;
      ovf       <= 1'b0;
    end else begin
      gate_d <= gate;
      if (take)        skip_pend <= 1'b0;
      else if (opened) skip_pend <= 1'b1;
      if (load) begin
        cnt <= load_val;
        ovf <= 1'b0;
      end else if (dec != 2'd0) begin
        cnt <= cnt - {{(CNT_W-2){1'b0}}, dec};
        if (cnt < {{(CNT_W-2){1'b0}}, dec}) ovf <= 1'b1;
      end
    end
  end

  // R2: a load sets the count and clears the wrap flag
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val) && !ovf));
  // R5: a closed gate freezes the count
  assert_closed_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!gate && !load) |=> $stable(cnt));
  // R3: without a load the count drops by at most the two edges of one cycle
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1 || cnt == $past(cnt) - 2'd2));
  // R8: leaving zero downward sets the sticky flag
  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0 && dec != 2'd0) |=> (ovf && cnt != '0));
  // R8: the flag stays set until a load
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (ovf && !load) |=> ovf);
endmodule

// File: rtl/gated_event_counter.sv
module gated_event_counter #(
  parameter int CNT_W     = 16,
  parameter int SYNC_STG  = 2,
  parameter int PULSE_W   = 6,
  parameter int PRIME_CYC = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_strobe,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid,
  input  logic             evt_in,
  output logic             wrapped
);
  import gec_pkg::*;

  logic             gate_q;
  logic             load;
  logic             ev_rise;
  logic             shaped;
  logic             shaped_fall;
  logic             prime_stb;
  logic [CNT_W-1:0] live_cnt;

  assign load = wr_en && (reg_sel_e'(wr_addr) == SEL_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en && reg_sel_e'(wr_addr) == SEL_CTRL) gate_q <= wr_data[0];
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= live_cnt;
    end
  end

  gec_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .async_in(evt_in), .rise(ev_rise));

  gec_shaper #(.PULSE_W(PULSE_W)) u_shape (
    .clk(clk), .rst(rst), .trig(ev_rise), .pulse(shaped), .fall_stb(shaped_fall));

  gec_prime #(.PRIME_CYC(PRIME_CYC)) u_prime (
    .clk(clk), .rst(rst), .gate(gate_q), .prime_stb(prime_stb));

  gec_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .gate(gate_q), .load(load), .load_val(wr_data),
    .ev_stb(shaped_fall), .prime_stb(prime_stb), .cnt(live_cnt), .ovf(wrapped));

  // R9: the read copy changes only after a read pulse
  assert_snapshot_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
  // R9: a read pulse yields a one-cycle valid
  assert_read_valid_R9: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid);
  // R6: a shaped event only ends after being high
  assert_fall_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    shaped_fall |-> !shaped && $past(shaped));
endmodule

// File: tb/gated_event_counter_bench.sv
module gated_event_counter_bench;
  localparam int PRIME = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        evt_in = 1'b0;
  logic        wrapped;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] exp_val_q[$];
  logic        exp_ovf_q[$];
  string       exp_tag_q[$];

  always #4 clk = ~clk;

  gated_event_counter u_gated_event_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_valid(rd_valid),
    .evt_in(evt_in), .wrapped(wrapped));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a read result appears
  always @(negedge clk) begin
    if (rd_valid && !rst) begin
      if (exp_val_q.size() == 0) begin
        check("R9 unexpected read", rd_data, 16'hxxxx);
      end else begin
        string       t;
        logic [15:0] v;
        logic        o;
        t = exp_tag_q.pop_front();
        v = exp_val_q.pop_front();
        o = exp_ovf_q.pop_front();
        check(t, rd_data, v);
        check({t, " flag"}, {15'd0, wrapped}, {15'd0, o});
      end
    end
  end

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] v, logic o, string t);
    @(negedge clk);
    exp_val_q.push_back(v); exp_ovf_q.push_back(o); exp_tag_q.push_back(t);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    evt_in = 1'b1;
    repeat (hi) @(negedge clk);
    evt_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    check("R1 reset flag", {15'd0, wrapped}, 16'd0);
    rd(16'h0000, 1'b0, "R1 reset count");

    wr(1'b0, 16'hFFFF);
    rd(16'hFFFF, 1'b0, "R2 load");

    // R4: empty window, priming event absorbed
    wr(1'b1, 16'd1); idle(40); wr(1'b1, 16'd0);
    rd(16'hFFFF, 1'b0, "R4 zero events");

    // R4: one event
    wr(1'b0, 16'hFFFF); wr(1'b1, 16'd1); idle(40);
    pulse(3, 14); wr(1'b1, 16'd0);
    rd(16'hFFFE, 1'b0, "R4 one event");

    // R3: five events, complement equals five
    wr(1'b0, 16'hFFFF); wr(1'b1, 16'd1); idle(40);
    for (int i = 0; i < 5; i++) pulse(3, 14);
    wr(1'b1, 16'd0);
    rd(16'hFFFA, 1'b0, "R3 five events");

    // R5: gate closed
    wr(1'b0, 16'h1234);
    for (int i = 0; i < 3; i++) pulse(3, 14);
    rd(16'h1234, 1'b0, "R5 closed gate");

    // R6: second rise inside the shaped pulse is ignored
    wr(1'b0, 16'hFFFF); wr(1'b1, 16'd1); idle(40);
    pulse(2, 2); pulse(2, 16); wr(1'b1, 16'd0);
    rd(16'hFFFE, 1'b0, "R6 shaper merge");

    // R7: sweep one event across the priming instant
    for (int off = PRIME - 16; off <= PRIME - 4; off++) begin
      wr(1'b0, 16'hFFFF);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'd1;
      @(negedge clk);
      wr_en = 1'b0;
      idle(off);
      pulse(3, 14);
      idle(PRIME);
      wr(1'b1, 16'd0);
      rd(16'hFFFE, 1'b0, $sformatf("R7 collision offset %0d", off));
    end

    // R8: wrap past zero and clear on load
    wr(1'b0, 16'h0002); wr(1'b1, 16'd1); idle(40);
    for (int i = 0; i < 3; i++) pulse(3, 14);
    rd(16'hFFFF, 1'b1, "R8 wrap");
    wr(1'b0, 16'h0005);
    rd(16'h0005, 1'b0, "R8 cleared by load");
    wr(1'b1, 16'd0);

    // R9: snapshot holds while the count moves
    wr(1'b0, 16'h0010); wr(1'b1, 16'd1); idle(40);
    rd(16'h0010, 1'b0, "R9 snapshot");
    pulse(3, 14); pulse(3, 14);
    check("R9 held copy", rd_data, 16'h0010);
    rd(16'h000E, 1'b0, "R9 new read");
    wr(1'b1, 16'd0);

    idle(4);
    check("R9 scoreboard drained", 16'(exp_val_q.size()), 16'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule